// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for every data beat of one double-data-rate memory burst. A start strobe loads a starting column, a burst length code (2, 4 or 8 beats) and an ordering flag that picks sequential or interleaved order. From the next cycle the block presents one column per beat. Each accepted advance moves it to the next beat, and a last flag marks the final beat.

The column bits above the burst block stay fixed for the whole burst. Only the low log2(length) bits move. In sequential order they count up from the start offset and wrap inside the block. In interleaved order they are the start offset XOR the beat index. Length and ordering are captured with the start strobe, so a memory controller can change its command fields while a burst is still running.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is asserted and after its release, before any start, `valid_o` and `last_o` are 0.
- R2: A start sampled at a clock edge makes `valid_o` 1 after that edge, with `col_o` equal to the sampled `start_col_i` (beat 0).
- R3: The length code `blen_i` decodes as 2'b00 = 2 beats, 2'b01 = 4 beats, 2'b10 = 8 beats; 2'b11 is handled as 8 beats.
- R4: With `itlv_i` = 0 (sequential), the low offset of beat k is (start offset + k) mod length.
- R5: With `itlv_i` = 1 (interleaved), the low offset of beat k is start offset XOR k.
- R6: Column bits at or above log2(length) equal those of the start column on every beat.
- R7: The beat moves forward only at an edge where `valid_o` and `advance_i` are both 1. Otherwise `col_o` and `valid_o` hold.
- R8: `last_o` is 1 exactly on beat length-1 while valid. An advance on that beat clears `valid_o`, unless a start arrives at the same edge.
- R9: A start during a burst takes priority over an advance and begins a new burst at beat 0.
- R10: Changes on `blen_i`, `itlv_i` and `start_col_i` after the start edge have no effect on the running burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load a new burst |
| start_col_i | input | COL_W | Starting column address |
| blen_i | input | 2 | Burst length code |
| itlv_i | input | 1 | 1 = interleaved order, 0 = sequential |
| advance_i | input | 1 | Move to the next beat |
| col_o | output | COL_W | Column for the current beat |
| valid_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench targets wrap points, for example a 4-beat sequential burst from offset 1. A design that carried into bit 2 instead of wrapping would emit column 4 where 0 is due, and would break the fixed upper bits. Interleaved bursts from odd offsets catch a design that adds where it should XOR: 5-4-7-6 would come out as 5-6-7-0. Stalls, restarts in mid-burst and back-to-back starts on the last beat catch a design that drops `valid_o` for one cycle or ignores the start priority. Changing the length and order inputs during a burst catches a design that fails to latch them.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

    localparam int OFS_W = 3;

    typedef enum logic [1:0] {
        BLEN_2   = 2'b00,
        BLEN_4   = 2'b01,
        BLEN_8   = 2'b10,
        BLEN_RSV = 2'b11
    } blen_code_e;

    typedef logic [OFS_W-1:0] ofs_t;

endpackage

// File: rtl/burst_mask_dec.sv
module burst_mask_dec
    import burst_seq_pkg::*;
(
    input  logic [1:0] code_i,
    output ofs_t       mask_o
);
    always_comb begin
        unique case (blen_code_e'(code_i))
            BLEN_2:  mask_o = 3'b001;
            BLEN_4:  mask_o = 3'b011;
            BLEN_8:  mask_o = 3'b111;
            default: mask_o = 3'b111;
        endcase
    end
endmodule

// File: rtl/burst_col_gen.sv
module burst_col_gen
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_i,
    input  ofs_t             beat_i,
    input  ofs_t             mask_i,
    input  logic             itlv_i,
    output logic [COL_W-1:0] col_o
);
    ofs_t seq_ofs;
    ofs_t xor_ofs;

    assign seq_ofs = base_i[OFS_W-1:0] + beat_i;
    assign xor_ofs = base_i[OFS_W-1:0] ^ beat_i;

    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        if (i < OFS_W) begin : g_low
            assign col_o[i] = mask_i[i] ? (itlv_i ? xor_ofs[i] : seq_ofs[i])
                                        : base_i[i];
        end else begin : g_high
            assign col_o[i] = base_i[i];
        end
    end
endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
    import burst_seq_pkg::*;
#(
    parameter int COL_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [COL_W-1:0] start_col_i,
    input  logic [1:0]       blen_i,
    input  logic             itlv_i,
    input  logic             advance_i,
    output logic [COL_W-1:0] col_o,
    output logic             valid_o,
    output logic             last_o
);
    typedef struct packed {
        logic             valid;
        ofs_t             beat;
        ofs_t             mask;
        logic             itlv;
        logic [COL_W-1:0] base;
    } state_t;

    state_t st_d, st_q;
    ofs_t   dec_mask;
    logic   at_end;
    logic   [COL_W-1:0] gen_col;

    burst_mask_dec u_dec (
        .code_i (blen_i),
        .mask_o (dec_mask)
    );

    burst_col_gen #(.COL_W(COL_W)) u_gen (
        .base_i (st_q.base),
        .beat_i (st_q.beat),
        .mask_i (st_q.mask),
        .itlv_i (st_q.itlv),
        .col_o  (gen_col)
    );

    assign at_end = (st_q.beat == st_q.mask);

    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d.valid = 1'b1;
            st_d.beat  = '0;
            st_d.mask  = dec_mask;
            st_d.itlv  = itlv_i;
            st_d.base  = start_col_i;
        end else if (st_q.valid && advance_i) begin
            if (at_end) begin
                st_d.valid = 1'b0;
                st_d.beat  = '0;
            end else begin
                st_d.beat = st_q.beat + 3'd1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = st_q.valid;
    assign last_o  = st_q.valid && at_end;
    assign col_o   = st_q.valid ? gen_col : '0;
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [COL_W-1:0] start_col_i,
    input logic             advance_i,
    input logic [COL_W-1:0] col_o,
    input logic             valid_o,
    input logic             last_o
);
    AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |-> valid_o); // R8

    AST_START_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (valid_o && col_o == $past(start_col_i))); // R2

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !advance_i && !start_i) |=> (valid_o && $stable(col_o))); // R7

    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !last_o && !start_i) |=> (col_o[COL_W-1:3] == $past(col_o[COL_W-1:3]))); // R6

    AST_END_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (last_o && advance_i && !start_i) |=> !valid_o); // R8

    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_o && !start_i) |=> !valid_o); // R1
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .advance_i   (advance_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .last_o      (last_o)
);

// File: tb/burst_col_seq_tb.sv
module burst_col_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int COL_W      = 10;

    logic             clk = 1'b0;
    logic             rst_n;
    logic             start_i;
    logic [COL_W-1:0] start_col_i;
    logic [1:0]       blen_i;
    logic             itlv_i;
    logic             advance_i;
    logic [COL_W-1:0] col_o;
    logic             valid_o;
    logic             last_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    burst_col_seq #(.COL_W(COL_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .start_col_i(start_col_i),
        .blen_i(blen_i), .itlv_i(itlv_i), .advance_i(advance_i),
        .col_o(col_o), .valid_o(valid_o), .last_o(last_o)
    );

    // R3 encoding
    function automatic int code_len(input logic [1:0] code);
        case (code)
            2'b00:   return 2;
            2'b01:   return 4;
            default: return 8;
        endcase
    endfunction

    function automatic logic [COL_W-1:0] exp_col(input logic [COL_W-1:0] s,
            input int bl, input logic il, input int k);
        int base = int'(s) - (int'(s) % bl);
        int ofs  = int'(s) % bl;
        int nofs = il ? (ofs ^ k) : ((ofs + k) % bl);
        return COL_W'(base + nofs);
    endfunction

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [COL_W-1:0] c, input logic [1:0] code, input logic il);
        start_i = 1'b1; start_col_i = c; blen_i = code; itlv_i = il;
        cyc();
        start_i = 1'b0;
    endtask

    // runs a loaded burst to its end; scramble exercises R10, stall exercises R7
    task automatic run_burst(input logic [COL_W-1:0] c, input logic [1:0] code,
            input logic il, input bit stall, input bit scramble);
        int bl = code_len(code);
        int k = 0;
        do_start(c, code, il);
        if (scramble) begin
            blen_i = ~code; itlv_i = ~il; start_col_i = ~c;
        end
        while (k < bl) begin
            logic [COL_W-1:0] e = exp_col(c, bl, il, k);
            chk(il ? "R5 interleaved col" : "R4 sequential col", 32'(col_o), 32'(e));
            chk("R6 upper bits", 32'(col_o / bl), 32'(c / bl));
            chk("R8 last flag", 32'(last_o), 32'(k == bl - 1));
            chk("R7 valid during burst", 32'(valid_o), 32'd1);
            if (stall && ($urandom % 4 == 0)) begin
                advance_i = 1'b0;
                cyc();
                chk("R7 stall holds col", 32'(col_o), 32'(e));
            end else begin
                advance_i = 1'b1;
                cyc();
                k++;
            end
        end
        advance_i = 1'b0;
        chk("R8 valid drops after last", 32'(valid_o), 32'd0);
        chk("R8 last clear after end", 32'(last_o), 32'd0);
    endtask

    bit done = 1'b0;

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0; start_i = 1'b0; start_col_i = '0; blen_i = 2'b00;
        itlv_i = 1'b0; advance_i = 1'b0;
        repeat (3) cyc();
        chk("R1 reset valid", 32'(valid_o), 32'd0);
        chk("R1 reset last", 32'(last_o), 32'd0);
        rst_n = 1'b1;
        advance_i = 1'b1;
        repeat (2) cyc();
        chk("R1 idle valid", 32'(valid_o), 32'd0);
        advance_i = 1'b0;

        // R2: start presents beat 0
        do_start(10'h2A5, 2'b10, 1'b1);
        chk("R2 start valid", 32'(valid_o), 32'd1);
        chk("R2 start col", 32'(col_o), 32'h2A5);
        advance_i = 1'b1;
        repeat (8) cyc();
        advance_i = 1'b0;

        // R4 sequential wrap: 4 beats from offset 1 -> 1,2,3,0
        run_burst(10'h101, 2'b01, 1'b0, 1'b0, 1'b0);
        // R5 interleaved: 8 from 5 -> 5,4,7,6,1,0,3,2 ; 4 from 3 -> 3,2,1,0
        run_burst(10'h0F5, 2'b10, 1'b1, 1'b0, 1'b0);
        run_burst(10'h0F3, 2'b01, 1'b1, 1'b0, 1'b0);
        // R3 length 2 and reserved code as 8
        run_burst(10'h3FF, 2'b00, 1'b0, 1'b0, 1'b0);
        run_burst(10'h006, 2'b11, 1'b0, 1'b0, 1'b0);
        // R10 inputs changed mid-burst
        run_burst(10'h1C6, 2'b10, 1'b0, 1'b1, 1'b1);
        run_burst(10'h0B2, 2'b01, 1'b1, 1'b0, 1'b1);

        // R9 restart mid-burst with advance high
        do_start(10'h044, 2'b10, 1'b0);
        advance_i = 1'b1;
        repeat (2) cyc();
        start_i = 1'b1; start_col_i = 10'h1F9; blen_i = 2'b01; itlv_i = 1'b1;
        cyc();
        start_i = 1'b0;
        chk("R9 restart col", 32'(col_o), 32'h1F9);
        cyc();
        chk("R9 restart beat1", 32'(col_o), 32'h1F8);
        repeat (2) cyc();
        chk("R9 restart last", 32'(last_o), 32'd1);
        // R8 back-to-back start on last beat keeps valid
        start_i = 1'b1; start_col_i = 10'h033; blen_i = 2'b00; itlv_i = 1'b0;
        cyc();
        start_i = 1'b0; advance_i = 1'b0;
        chk("R8 back-to-back valid", 32'(valid_o), 32'd1);
        chk("R8 back-to-back col", 32'(col_o), 32'h033);
        advance_i = 1'b1;
        repeat (2) cyc();
        advance_i = 1'b0;
        chk("R8 back-to-back end", 32'(valid_o), 32'd0);

        for (int n = 0; n < 300; n++) begin
            run_burst(COL_W'($urandom), 2'($urandom), 1'($urandom), 1'b1, 1'($urandom));
        end

        done = 1'b1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule